// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset and a segment value into a 20-bit byte address for a one-megabyte space. It keeps four 16-bit segment registers (code, data, extra, stack). Each access request carries an offset and an access class. The block picks the segment register that the class calls for, optionally replaced by an override for data-class accesses. It shifts that segment left by four bits, adds the offset and returns the result one clock later with a valid strobe. It also returns the index of the segment register it used.

Software or a sequencer loads a segment register through a simple write port. A write becomes visible to requests from the next clock onward. Class codes: 0 instruction fetch, 1 stack, 2 data source, 3 string destination, 4 base-relative data; codes 5 to 7 are treated as data source. Segment index codes: 0 code, 1 data, 2 extra, 3 stack.

Top module: `segaddr_gen`

## Requirements
- R1: For a request, phys_addr equals (segment value × 16 + offset) taken modulo 2^20, where segment value is the register named by seg_used.
- R2: A sum past 0xFFFFF wraps around, so for example segment 0xFFFF with offset 0x0010 gives address 0x00000.
- R3: Class 0 (fetch) always uses segment index 0 (code), whatever the override inputs are.
- R4: Class 1 (stack) always uses segment index 3 (stack), whatever the override inputs are.
- R5: With ovr_en low, class 2 uses index 1 (data), class 3 uses index 2 (extra) and class 4 uses index 3 (stack).
- R6: With ovr_en high, classes 2, 3 and 4 use the segment index given on ovr_sel.
- R7: addr_valid is high in exactly the cycle after a cycle with req_valid high, and phys_addr and seg_used carry that request's result in that cycle.
- R8: In the cycle after a cycle with req_valid low, addr_valid is low and phys_addr and seg_used keep their previous values.
- R9: A segment write takes effect for requests in later cycles. A request in the same cycle as the write uses the old value.
- R10: After reset, all four segment registers, phys_addr, seg_used and addr_valid are zero.
- R11: Class codes 5, 6 and 7 behave as class 2 (data source), including the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Load a segment register |
| seg_wr_sel | input | 2 | Segment register to load (index code) |
| seg_wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Access request present |
| req_class | input | 3 | Access class code |
| req_offset | input | 16 | Offset within the segment |
| ovr_en | input | 1 | Use ovr_sel instead of the default for data classes |
| ovr_sel | input | 2 | Override segment index |
| phys_addr | output | 20 | Registered physical address |
| seg_used | output | 2 | Registered index of the segment used |
| addr_valid | output | 1 | Result strobe, one cycle after the request |

## Verification
The hardest case to reach from the ports is a write and a request to the same segment register in the same cycle. Catching it needs the write-then-read ordering and an offset with a visible difference. The bench drives this case directly and also reaches it in the random loop, where writes and requests share cycles. The wrap-around case needs the segment near 0xFFFF together with a large offset. The bench loads such values directly and also biases random segment values toward the top of the range.

// File: rtl/segaddr_pkg.sv
// Shared encodings for the segmented address generator.
// Assumes: four segment registers, five defined access classes.
package segaddr_pkg;
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_STACK = 2'd3
    } seg_idx_t;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_STACK = 3'd1,
        ACC_SRC   = 3'd2,
        ACC_DST   = 3'd3,
        ACC_BASE  = 3'd4
    } acc_class_t;

    localparam int NUM_SEGS = 4;
endpackage

// File: rtl/segaddr_regfile.sv
// Holds the segment registers and gives out all of them in parallel.
// Assumes: one write per cycle; a write is seen by readers from the next cycle.
module segaddr_regfile #(
    parameter int SEG_W = 16,
    parameter int NSEG  = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [SEG_W-1:0]           wr_data,
    output logic [NSEG-1:0][SEG_W-1:0] seg_q
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        // Load one register when it is addressed, clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                seg_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/segaddr_select.sv
// Picks a segment index from the access class and the override inputs.
// Assumes: fetch and stack classes are never overridden; unknown codes act as data source.
module segaddr_select
    import segaddr_pkg::*;
(
    input  logic [2:0] acc_class,
    input  logic       ovr_en,
    input  logic [1:0] ovr_sel,
    output seg_idx_t   seg_idx
);
    // Map the class to its default segment, then apply the override to data classes.
    always_comb begin
        unique case (acc_class)
            ACC_FETCH: seg_idx = SEG_CODE;
            ACC_STACK: seg_idx = SEG_STACK;
            ACC_DST:   seg_idx = ovr_en ? seg_idx_t'(ovr_sel) : SEG_EXTRA;
            ACC_BASE:  seg_idx = ovr_en ? seg_idx_t'(ovr_sel) : SEG_STACK;
            default:   seg_idx = ovr_en ? seg_idx_t'(ovr_sel) : SEG_DATA;
        endcase
    end
endmodule

// File: rtl/segaddr_adder.sv
// Forms segment * 2^SHIFT + offset, truncated to ADDR_W bits (wraps on overflow).
// Assumes: OFF_W <= SEG_W + SHIFT.
module segaddr_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] seg_sh;
    logic [ADDR_W-1:0] off_ext;

    // Align the segment, widen the offset, and add modulo 2^ADDR_W.
    always_comb begin
        seg_sh  = ADDR_W'(seg) << SHIFT;
        off_ext = ADDR_W'(offset);
        addr    = seg_sh + off_ext;
    end
endmodule

// File: rtl/segaddr_gen.sv
// Top: segment register file, segment choice and address add, with a registered result.
// Assumes: one request per cycle; the result appears one cycle after the request.
module segaddr_gen
    import segaddr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [1:0]        seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              req_valid,
    input  logic [2:0]        req_class,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              ovr_en,
    input  logic [1:0]        ovr_sel,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [1:0]        seg_used,
    output logic              addr_valid
);
    logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
    seg_idx_t                       idx;
    logic [ADDR_W-1:0]              addr_d;

    segaddr_regfile #(.SEG_W(SEG_W), .NSEG(NUM_SEGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(seg_wr_en), .wr_sel(seg_wr_sel),
        .wr_data(seg_wr_data), .seg_q(seg_q)
    );

    segaddr_select u_sel (
        .acc_class(req_class), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .seg_idx(idx)
    );

    segaddr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg(seg_q[idx]), .offset(req_offset), .addr(addr_d)
    );

    // Capture the result for a request; hold the last result otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr  <= '0;
            seg_used   <= '0;
            addr_valid <= 1'b0;
        end else begin
            addr_valid <= req_valid;
            if (req_valid) begin
                phys_addr <= addr_d;
                seg_used  <= idx;
            end
        end
    end
endmodule

// File: rtl/segaddr_chk.sv
// Checker bound to segaddr_gen: timing and segment-choice properties seen at its ports.
// Assumes: synchronous active-low reset; all properties are disabled while reset is low.
module segaddr_chk #(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_class,
    input logic [OFF_W-1:0]  req_offset,
    input logic              ovr_en,
    input logic [ADDR_W-1:0] phys_addr,
    input logic [1:0]        seg_used,
    input logic              addr_valid
);
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid);
    assert_idle_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !addr_valid);
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(phys_addr) && $stable(seg_used)));
    assert_fetch_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 3'd0) |=> seg_used == 2'd0);
    assert_stack_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 3'd1) |=> seg_used == 2'd3);
    assert_base_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 3'd4 && !ovr_en) |=> seg_used == 2'd3);
    assert_low_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> phys_addr[3:0] == $past(req_offset[3:0]));
endmodule

bind segaddr_gen segaddr_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_offset(req_offset), .ovr_en(ovr_en), .phys_addr(phys_addr),
    .seg_used(seg_used), .addr_valid(addr_valid)
);

// File: tb/sim_segaddr_gen.sv
// Bench for segaddr_gen: directed corners plus seeded random requests against a model.
module sim_segaddr_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        req_valid;
    logic [2:0]  req_class;
    logic [15:0] req_offset;
    logic        ovr_en;
    logic [1:0]  ovr_sel;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;
    logic        addr_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] seg_m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    segaddr_gen u0 (
        .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
        .seg_wr_data(seg_wr_data), .req_valid(req_valid), .req_class(req_class),
        .req_offset(req_offset), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .phys_addr(phys_addr), .seg_used(seg_used), .addr_valid(addr_valid)
    );

    function automatic logic [1:0] exp_idx(input logic [2:0] c, input logic en,
                                           input logic [1:0] sel);
        case (c)
            3'd0: return 2'd0;
            3'd1: return 2'd3;
            3'd3: return en ? sel : 2'd2;
            3'd4: return en ? sel : 2'd3;
            default: return en ? sel : 2'd1;
        endcase
    endfunction

    function automatic logic [19:0] exp_addr(input logic [15:0] s, input logic [15:0] o);
        return 20'({4'd0, s} * 20'd16 + {4'd0, o});
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: optional segment write and optional request, then check the result.
    task automatic step(input bit we, input logic [1:0] wsel, input logic [15:0] wdata,
                        input bit rv, input logic [2:0] c, input logic [15:0] off,
                        input logic en, input logic [1:0] sel, input string req);
        logic [19:0] prev_addr;
        logic [1:0]  prev_idx;
        logic [1:0]  ei;
        logic [19:0] ea;
        @(negedge clk);
        prev_addr = phys_addr;
        prev_idx = seg_used;
        seg_wr_en = we; seg_wr_sel = wsel; seg_wr_data = wdata;
        req_valid = rv; req_class = c; req_offset = off; ovr_en = en; ovr_sel = sel;
        ei = exp_idx(c, en, sel);
        ea = exp_addr(seg_m[ei], off);
        @(posedge clk);
        #1;
        seg_wr_en = 1'b0; req_valid = 1'b0;
        if (we) seg_m[wsel] = wdata;
        if (rv) begin
            check(addr_valid == 1'b1, {req, " R7 valid"}, 32'(addr_valid), 32'd1);
            check(seg_used == ei, {req, " seg_used"}, 32'(seg_used), 32'(ei));
            check(phys_addr == ea, {req, " R1 addr"}, 32'(phys_addr), 32'(ea));
        end else begin
            check(addr_valid == 1'b0, "R8 idle valid", 32'(addr_valid), 32'd0);
            check(phys_addr == prev_addr && seg_used == prev_idx, "R8 idle hold",
                  32'(phys_addr), 32'(prev_addr));
        end
    endtask

    task automatic load(input logic [1:0] s, input logic [15:0] v);
        step(1'b1, s, v, 1'b0, 3'd0, 16'd0, 1'b0, 2'd0, "load");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) seg_m[i] = 16'd0;
        rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = '0; seg_wr_data = '0;
        req_valid = 1'b0; req_class = '0; req_offset = '0; ovr_en = 1'b0; ovr_sel = '0;
        repeat (3) @(posedge clk);
        #1;
        check(phys_addr == 20'd0 && seg_used == 2'd0 && addr_valid == 1'b0, "R10 reset outs",
              32'(phys_addr), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: registers cleared, so every class returns the bare offset.
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd1, 16'h1234, 1'b0, 2'd0, "R10 zero segs");

        load(2'd0, 16'h1000); load(2'd1, 16'h250A); load(2'd2, 16'h2EF0); load(2'd3, 16'h5F00);
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd0, 16'h0100, 1'b1, 2'd2, "R3 fetch override ignored");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd1, 16'hFFFE, 1'b1, 2'd1, "R4 stack override ignored");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd2, 16'h0001, 1'b0, 2'd0, "R5 source default");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd3, 16'h0001, 1'b0, 2'd0, "R5 dest default");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd4, 16'h1009, 1'b0, 2'd0, "R5 base default");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd2, 16'h0040, 1'b1, 2'd3, "R6 source override");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd3, 16'h0040, 1'b1, 2'd1, "R6 dest override");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd4, 16'h0040, 1'b1, 2'd0, "R6 base override");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd6, 16'h0022, 1'b0, 2'd0, "R11 code 6 default");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd7, 16'h0022, 1'b1, 2'd2, "R11 code 7 override");
        step(1'b0, 2'd0, 16'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 2'd0, "R8 idle");
        // R2: wrap past the top of the space.
        load(2'd1, 16'hFFFF);
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd2, 16'h0010, 1'b0, 2'd0, "R2 wrap to zero");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd2, 16'hFFFF, 1'b0, 2'd0, "R2 wrap max");
        // R9: write and request in the same cycle use the old value, next cycle the new.
        step(1'b1, 2'd1, 16'h0123, 1'b1, 3'd2, 16'h0005, 1'b0, 2'd0, "R9 same cycle old");
        step(1'b0, 2'd0, 16'd0, 1'b1, 3'd2, 16'h0005, 1'b0, 2'd0, "R9 next cycle new");

        void'($urandom(32'd4242));
        for (int n = 0; n < 400; n++) begin
            logic [15:0] wv;
            wv = 16'($urandom);
            if ($urandom % 4 == 0) wv = 16'hFF00 | wv;
            step(1'($urandom % 3 == 0), 2'($urandom), wv, 1'($urandom % 5 != 0),
                 3'($urandom), 16'($urandom), 1'($urandom), 2'($urandom), "R1 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule